// File: doc/BRIEF.md
# Three-Wire Host Command Port

This block is the slave end of a three-wire serial link. A host microcontroller uses it to write and read a small bank of 8-bit configuration registers that the servo logic consumes. The link has a serial clock, a data line that turns around for reads, and a load line. The host drives the clock and may run it with no relation to the system clock, so all three inputs are brought into the system clock domain through synchronisers, and edges are found there.

The load line frames the traffic. The host shifts a byte in, most significant bit first, while load is low, with one bit sampled on each rising serial clock edge. It then raises load to commit that byte. The first byte of an exchange is a command. Bit 7 picks the direction (1 = read, 0 = write). Bits 6:4 give the number of data bytes that follow a write (0 to 7). Bits 3:0 give the first register address. The address advances by one after each byte and wraps modulo 16. After a read command, the host keeps load high and clocks the data out for as many bytes as it wants. Dropping load ends the read, and the next byte shifted in is a new command.

The whole register bank is presented in parallel on one output bus, so the servo core can use it directly.

Top module: `hif_serial_port`

## Requirements
- R1: After reset all 16 registers read 0, and the data output enable `sdo_oe_o` and `sdo_o` are low.
- R2: A byte is assembled most significant bit first from `sdi_i`, with one bit taken on each rising edge of `sclk_i` while `load_i` is low. A rising edge of `load_i` commits the byte.
- R3: A committed command with bit 7 = 0 and count bits 6:4 = N > 0 is a write. The next N committed bytes are stored at address bits 3:0, then at address+1 and so on, wrapping modulo 16. The register bank appears on `regs_o`, with register r at bits [8r+7:8r].
- R4: A write command with count 0 changes no register, and registers change only when a data byte of a write is committed.
- R5: Once N data bytes of a write are committed, the next committed byte is decoded as a new command.
- R6: A committed command with bit 7 = 1 is a read. The port presents the register at address bits 3:0 on `sdo_o`, most significant bit first, and moves to the next bit after each rising `sclk_i` while `load_i` is high. After every 8 bits it continues with the next address, wrapping modulo 16, for any number of bytes.
- R7: `sdo_oe_o` is high only during a read exchange while `load_i` is high. It is low during command and write bytes.
- R8: If `load_i` rises after fewer or more than 8 bits, the byte is discarded and the port returns to waiting for a command. No register changes.
- R9: Rising `sclk_i` edges while `load_i` is high outside a read do not shift data or disturb the byte count.
- R10: A falling `load_i` ends a read. `sdo_oe_o` drops, and the following byte is decoded as a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| sclk_i | input | 1 | host serial clock (asynchronous) |
| sdi_i | input | 1 | serial data from host |
| load_i | input | 1 | framing line: low while shifting in, rising edge commits a byte, held high during reads |
| sdo_o | output | 1 | serial read data to host |
| sdo_oe_o | output | 1 | output enable for the data line driver |
| regs_o | output | 128 | parallel view of the 16 registers |

## Verification
The bench aims at four corner cases. A write that runs across address 15 must wrap to 0; a port that does not wrap writes past the bank or into the wrong register. A count-zero command, and the byte that follows the last write byte, must both be decoded as commands; a port that gets this wrong stores a command byte as data. Short bytes, over-long bytes and serial clocks seen while load is high must be dropped or ignored; a port that gets this wrong commits a misaligned byte. A long read runs through 20 bytes and wraps the address, and the output enable is checked on both sides of the read; a port that gets this wrong returns stale bytes after the first, or drives the line during writes.

// File: rtl/hif_pkg.sv
package hif_pkg;
  typedef enum logic [1:0] {
    ST_CMD = 2'd0,
    ST_WR  = 2'd1,
    ST_RD  = 2'd2
  } hif_state_e;
endpackage

// File: rtl/hif_sync.sv
module hif_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
        else         pipe_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/hif_regfile.sv
module hif_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int NREG  = 1 << ADDR_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      waddr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [ADDR_W-1:0]      raddr_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [NREG*DATA_W-1:0] regs_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                               q <= '0;
      else if (we_i && waddr_i == ADDR_W'(r))    q <= wdata_i;
    assign regs_o[r*DATA_W +: DATA_W] = q;
  end

  assign rdata_o = regs_o[raddr_i*DATA_W +: DATA_W];

  AST_REGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_o)); // R4
endmodule

// File: rtl/hif_tx.sv
module hif_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              sdo_o
);
  logic [DATA_W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      sreg_q <= '0;
    else if (load_i)  sreg_q <= data_i;
    else if (shift_i) sreg_q <= {sreg_q[DATA_W-2:0], 1'b0};

  assign sdo_o = sreg_q[DATA_W-1];

  AST_TX_MSB_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> sdo_o == $past(sreg_q[DATA_W-2])); // R6
endmodule

// File: rtl/hif_serial_port.sv
module hif_serial_port
  import hif_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W     = 8,
  localparam int NREG       = 1 << ADDR_W,
  localparam int CNT_W      = DATA_W - 1 - ADDR_W,
  localparam int RXC_W      = $clog2(DATA_W + 2),
  localparam int TXB_W      = $clog2(DATA_W)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sclk_i,
  input  logic                   sdi_i,
  input  logic                   load_i,
  output logic                   sdo_o,
  output logic                   sdo_oe_o,
  output logic [NREG*DATA_W-1:0] regs_o
);
  localparam logic [RXC_W-1:0] RX_FULL = RXC_W'(DATA_W);
  localparam logic [RXC_W-1:0] RX_OVER = RXC_W'(DATA_W + 1);

  logic [2:0] sync_s;
  logic [1:0] prev_q;
  logic sclk_s, sdi_s, load_s;
  logic sclk_rise, load_rise, load_fall;

  hif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk_i, .rst_ni, .d_i({sclk_i, sdi_i, load_i}), .q_o(sync_s)
  );
  assign {sclk_s, sdi_s, load_s} = sync_s;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 2'b01;
    else         prev_q <= {sclk_s, load_s};

  assign sclk_rise = sclk_s & ~prev_q[1];
  assign load_rise = load_s & ~prev_q[0];
  assign load_fall = ~load_s & prev_q[0];

  hif_state_e        state_q;
  logic [DATA_W-1:0] rx_q;
  logic [RXC_W-1:0]  rx_cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [TXB_W-1:0]  tx_bit_q;
  logic              reload_q;
  logic              byte_ok, wr_en, tx_shift;
  logic [DATA_W-1:0] rd_data;

  logic              cmd_rd;
  logic [CNT_W-1:0]  cmd_cnt;
  logic [ADDR_W-1:0] cmd_addr;
  assign cmd_rd   = rx_q[DATA_W-1];
  assign cmd_cnt  = rx_q[DATA_W-2 -: CNT_W];
  assign cmd_addr = rx_q[ADDR_W-1:0];

  assign byte_ok  = (rx_cnt_q == RX_FULL);
  assign wr_en    = (state_q == ST_WR) && load_rise && byte_ok;
  assign tx_shift = (state_q == ST_RD) && load_s && sclk_rise;

  // receive shifter: only while load is low
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rx_q     <= '0;
      rx_cnt_q <= '0;
    end else if (load_rise || load_fall) begin
      rx_cnt_q <= '0;
    end else if (sclk_rise && !load_s) begin
      rx_q <= {rx_q[DATA_W-2:0], sdi_s};
      if (rx_cnt_q != RX_OVER) rx_cnt_q <= rx_cnt_q + RXC_W'(1);
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q  <= ST_CMD;
      addr_q   <= '0;
      left_q   <= '0;
      tx_bit_q <= '0;
      reload_q <= 1'b0;
    end else begin
      reload_q <= 1'b0;
      unique case (state_q)
        ST_CMD: if (load_rise && byte_ok) begin
          addr_q <= cmd_addr;
          if (cmd_rd) begin
            state_q  <= ST_RD;
            tx_bit_q <= '0;
            reload_q <= 1'b1;
          end else if (cmd_cnt != '0) begin
            state_q <= ST_WR;
            left_q  <= cmd_cnt;
          end
        end
        ST_WR: if (load_rise) begin
          if (byte_ok) begin
            addr_q <= addr_q + ADDR_W'(1);
            left_q <= left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) state_q <= ST_CMD;
          end else begin
            state_q <= ST_CMD;  // malformed byte aborts
          end
        end
        ST_RD: if (load_fall) begin
          state_q <= ST_CMD;
        end else if (tx_shift) begin
          tx_bit_q <= tx_bit_q + TXB_W'(1);
          if (tx_bit_q == TXB_W'(DATA_W - 1)) begin
            addr_q   <= addr_q + ADDR_W'(1);
            reload_q <= 1'b1;
          end
        end
        default: state_q <= ST_CMD;
      endcase
    end

  hif_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
    .clk_i, .rst_ni,
    .we_i(wr_en), .waddr_i(addr_q), .wdata_i(rx_q),
    .raddr_i(addr_q), .rdata_o(rd_data), .regs_o(regs_o)
  );

  logic tx_sdo;
  hif_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni,
    .load_i(reload_q), .data_i(rd_data), .shift_i(tx_shift), .sdo_o(tx_sdo)
  );

  assign sdo_oe_o = (state_q == ST_RD) && load_s;
  assign sdo_o    = sdo_oe_o & tx_sdo;

  AST_RD_FROM_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_RD) |-> $past(load_rise && cmd_rd && byte_ok)); // R6
  AST_WR_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en) |-> addr_q == $past(addr_q) + ADDR_W'(1)); // R3
  AST_RD_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD && load_fall) |=> !sdo_oe_o); // R10
  AST_RX_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt_q <= RX_OVER); // R8
  AST_HIGH_CLK_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise && load_s && !load_rise && state_q != ST_RD) |=> rx_cnt_q == $past(rx_cnt_q)); // R9
endmodule

// File: tb/hif_serial_port_tb_top.sv
module hif_serial_port_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk_i = 1'b0;
  logic sdi_i = 1'b0;
  logic load_i = 1'b1;
  logic sdo_o, sdo_oe_o;
  logic [127:0] regs_o;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] model [16];

  always #5 clk_i = ~clk_i;

  hif_serial_port dut_i (
    .clk_i, .rst_ni, .sclk_i, .sdi_i, .load_i, .sdo_o, .sdo_oe_o, .regs_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [7:0] b, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sdi_i = b[7-i];
      #30 sclk_i = 1'b1;
      #60 sclk_i = 1'b0;
      #30;
    end
  endtask

  task automatic begin_byte(); load_i = 1'b0; #100; endtask
  task automatic end_byte();   load_i = 1'b1; #200; endtask

  task automatic send_byte(input logic [7:0] b);
    begin_byte(); shift_bits(b, 8); end_byte();
  endtask

  task automatic check_regs(input string req);
    for (int r = 0; r < 16; r++) check(req, 32'(regs_o[r*8 +: 8]), 32'(model[r]));
  endtask

  task automatic write_xfer(input logic [7:0] cmd, input logic [55:0] data);
    int n = int'(cmd[6:4]);
    send_byte(cmd);
    for (int k = 0; k < n; k++) begin
      begin_byte();
      shift_bits(data[8*k +: 8], 8);
      check("R7 oe low in write", 32'(sdo_oe_o), 0);
      end_byte();
      model[(int'(cmd[3:0]) + k) % 16] = data[8*k +: 8];
    end
  endtask

  task automatic read_xfer(input logic [3:0] addr, input int nbytes);
    begin_byte(); shift_bits({4'b1000, addr}, 8); load_i = 1'b1; #200;
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] got = '0;
      check("R7 oe high in read", 32'(sdo_oe_o), 1);
      for (int i = 0; i < 8; i++) begin
        got[7-i] = sdo_o;
        #20 sclk_i = 1'b1;
        #60 sclk_i = 1'b0;
        #100;
      end
      check("R6 read byte", 32'(got), 32'(model[(int'(addr) + b) % 16]));
    end
    load_i = 1'b0; #100;
    check("R10 oe drops at load fall", 32'(sdo_oe_o), 0);
  endtask

  task automatic t_reset();
    check("R1 oe", 32'(sdo_oe_o), 0);
    check("R1 sdo", 32'(sdo_o), 0);
    check_regs("R1 regs zero");
  endtask

  task automatic t_single_write();
    write_xfer(8'h13, 56'hA5);  // count 1, addr 3
    check("R2 msb first", 32'(regs_o[3*8 +: 8]), 32'h00A5);
  endtask

  task automatic t_multi_wrap();
    write_xfer(8'h3E, 56'h33_22_11);  // count 3 from addr 14
    check_regs("R3 multi write wraps");
  endtask

  task automatic t_count_zero();
    send_byte(8'h07);
    send_byte(8'h00);
    check_regs("R4 count zero no change");
  endtask

  task automatic t_next_is_cmd();
    write_xfer(8'h11, 56'h3C);
    write_xfer(8'h12, 56'h5A);  // byte after last data is a command
    check("R5 first", 32'(regs_o[1*8 +: 8]), 32'h3C);
    check("R5 second", 32'(regs_o[2*8 +: 8]), 32'h5A);
  endtask

  task automatic t_malformed();
    send_byte(8'h14);
    begin_byte(); shift_bits(8'hFF, 5); end_byte();  // short data byte
    send_byte(8'h00);
    check("R8 short byte dropped", 32'(regs_o[4*8 +: 8]), 32'(model[4]));
    begin_byte(); shift_bits(8'h15, 8); shift_bits(8'h80, 1); end_byte();  // 9-bit command
    begin_byte(); shift_bits(8'h80, 8); load_i = 1'b1; #200; load_i = 1'b0; #100;
    check_regs("R8 long command dropped");
    write_xfer(8'h14, 56'h99);
    check("R8 recovers", 32'(regs_o[4*8 +: 8]), 32'h99);
  endtask

  task automatic t_high_clocks();
    send_byte(8'h18);
    sdi_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      sclk_i = 1'b1; #60; sclk_i = 1'b0; #60;
    end
    send_byte(8'h42);
    model[8] = 8'h42;
    check("R9 clocks with load high ignored", 32'(regs_o[8*8 +: 8]), 32'h42);
  endtask

  task automatic t_reads();
    read_xfer(4'd14, 4);
    read_xfer(4'd0, 20);
  endtask

  task automatic t_after_read();
    read_xfer(4'd3, 1);
    write_xfer(8'h16, 56'hE7);
    check("R10 command after read", 32'(regs_o[6*8 +: 8]), 32'hE7);
    check("R10 oe idle", 32'(sdo_oe_o), 0);
  endtask

  initial begin
    for (int r = 0; r < 16; r++) model[r] = '0;
    #53 rst_ni = 1'b1;
    #200;
    t_reset();
    t_single_write();
    t_multi_wrap();
    t_count_zero();
    t_next_is_cmd();
    t_malformed();
    t_high_clocks();
    t_reads();
    t_after_read();
    check_regs("R3 final bank");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule